// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block produces the four condition flags of a processor status word after an add or subtract: negative, zero, carry and signed overflow. It is given the source operand, the destination operand and the result from an adder elsewhere. A size select picks 8-bit or 16-bit operation, and the flags are derived from that size only.

Carry and overflow are not taken from the adder's carry chain. Both come from the sign bits of the source, destination and result, through two fixed eight-entry lookups. A registered status word holds the flags. It changes only when the update strobe is high. When the arithmetic flag is low, only the negative and zero flags are rewritten.

Top module: `psw_flag_gen`

## Requirements
- R1: The status word `psw_o` is laid out as bit 0 = carry, bit 1 = zero, bit 2 = negative, bit 3 = overflow. A clock edge with `rst_n` low clears all four bits.
- R2: After an update edge, the negative bit equals the result's sign bit. The sign bit is bit 7 when `byte_i` is 1 and bit 15 when `byte_i` is 0.
- R3: After an update edge, the zero bit is 1 when the result at the active size is all zeros, and 0 otherwise.
- R4: After an update edge with `arith_i` high, the overflow bit is 1 only when the sign bits of (source, destination, result) are 001 or 110.
- R5: After an update edge with `arith_i` high, the carry bit is 1 when the sign bits of (source, destination, result) are 010, 100, 110 or 111. It is 0 for 000, 001, 011 and 101.
- R6: On an update edge with `arith_i` low, the carry and overflow bits keep their previous values. The negative and zero bits still update.
- R7: On a clock edge with `upd_i` low, all four bits of `psw_o` keep their values, whatever the other inputs are.
- R8: When `byte_i` is 1, bits 15:8 of the source, destination and result have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| res_i | input | 16 | Adder result |
| byte_i | input | 1 | 1 = 8-bit size, 0 = 16-bit size |
| arith_i | input | 1 | 1 = carry and overflow may change |
| upd_i | input | 1 | Update strobe for the status word |
| psw_o | output | 4 | Registered status word {V, N, Z, C} |

## Verification
The properties assume that `byte_i`, `arith_i`, `upd_i` and the three data inputs are known, non-X values at every rising edge after reset. They also assume that reset is held low for at least one edge before any update.

The bench drives every input on the falling edge and keeps them steady through the next rising edge. It holds reset low for several edges before the first strobe, and it never leaves an input undriven. In byte mode, the upper bytes carry sign bits opposite to the lower bytes. The sign-bit combinations therefore reach the flags only through the correct lane.

// File: rtl/psw_pkg.sv
// Package: shared types and constants for the status flag generator.
// Assumes the status word holds exactly four flags in the order {V, N, Z, C}.
package psw_pkg;

    localparam int PSW_W = 4;

    // Flag record; the packed order fixes the bit positions of the status word.
    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } psw_t;

    // Lookups indexed by {src_msb, dst_msb, res_msb}; bit k answers index k.
    localparam logic [7:0] OVF_LUT   = 8'b0100_0010;
    localparam logic [7:0] CARRY_LUT = 8'b1101_0100;

endpackage

// File: rtl/psw_sign_pick.sv
// Module: psw_sign_pick
// Selects the sign bits of source, destination and result for the active
// operand size. It also reports whether the result is zero at that size.
// Assumes DATA_W is a whole multiple of LANE_W; the narrow size is lane 0.
module psw_sign_pick #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              narrow_i,
    output logic [2:0]        sign_o,
    output logic              zero_o
);

    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int NAR_MSB   = LANE_W - 1;
    localparam int WID_MSB   = DATA_W - 1;

    logic [NUM_LANES-1:0] lane_zero;

    // One zero detector per lane, so the narrow size can reuse lane 0 alone.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_zero[g] = ~|res_i[g*LANE_W +: LANE_W];
    end

    // Choose the sign bits and the zero result for the active size.
    always_comb begin
        if (narrow_i) begin
            sign_o = {src_i[NAR_MSB], dst_i[NAR_MSB], res_i[NAR_MSB]};
            zero_o = lane_zero[0];
        end else begin
            sign_o = {src_i[WID_MSB], dst_i[WID_MSB], res_i[WID_MSB]};
            zero_o = &lane_zero;
        end
    end

endmodule

// File: rtl/psw_flag_lut.sv
// Module: psw_flag_lut
// Turns the three sign bits into the next flag values. Carry and overflow
// come from the fixed lookups in the package. Negative is the result sign.
// Assumes sign_i is ordered {src, dst, res} from bit 2 down to bit 0.
module psw_flag_lut
    import psw_pkg::*;
(
    input  logic [2:0] sign_i,
    input  logic       zero_i,
    output psw_t       flags_o
);

    // Index the lookups and assemble the candidate flag record.
    always_comb begin
        flags_o.c = CARRY_LUT[sign_i];
        flags_o.v = OVF_LUT[sign_i];
        flags_o.n = sign_i[0];
        flags_o.z = zero_i;
    end

endmodule

// File: rtl/psw_store.sv
// Module: psw_store
// Status word register. N and Z load on every strobe. C and V load only
// when the arithmetic enable is also high.
// Assumes a synchronous, active-low reset that clears every flag.
module psw_store
    import psw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic arith_i,
    input  psw_t next_i,
    output psw_t psw_o
);

    psw_t psw_q;

    // Hold, partly reload or fully reload the flags on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw_q <= '0;
        end else if (load_i) begin
            psw_q.n <= next_i.n;
            psw_q.z <= next_i.z;
            if (arith_i) begin
                psw_q.c <= next_i.c;
                psw_q.v <= next_i.v;
            end
        end
    end

    assign psw_o = psw_q;

endmodule

// File: rtl/psw_flag_gen.sv
// Module: psw_flag_gen (top)
// Computes N, Z, C and V for a byte or word add or subtract from the
// operands and the result. The flags are registered under an update strobe.
// Assumes the adder and the instruction decode live outside this block.
module psw_flag_gen
    import psw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              byte_i,
    input  logic              arith_i,
    input  logic              upd_i,
    output logic [PSW_W-1:0]  psw_o
);

    logic [2:0] sign_w;
    logic       zero_w;
    psw_t       next_w;
    psw_t       psw_w;

    psw_sign_pick #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_pick (
        .src_i    (src_i),
        .dst_i    (dst_i),
        .res_i    (res_i),
        .narrow_i (byte_i),
        .sign_o   (sign_w),
        .zero_o   (zero_w)
    );

    psw_flag_lut u_lut (
        .sign_i  (sign_w),
        .zero_i  (zero_w),
        .flags_o (next_w)
    );

    psw_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (upd_i),
        .arith_i (arith_i),
        .next_i  (next_w),
        .psw_o   (psw_w)
    );

    // Present the flag record as a plain vector.
    always_comb begin
        psw_o = psw_w;
    end

endmodule

// File: rtl/psw_flag_gen_chk.sv
// Module: psw_flag_gen_chk
// Property checker bound to psw_flag_gen. It watches only the ports.
// Assumes known inputs at every rising edge after reset.
module psw_flag_gen_chk #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] src_i,
    input logic [DATA_W-1:0] dst_i,
    input logic [DATA_W-1:0] res_i,
    input logic              byte_i,
    input logic              arith_i,
    input logic              upd_i,
    input logic [3:0]        psw_o
);

    logic s_sg, d_sg, r_sg, r_nil;

    // Sign bits and zero result at the active size, as seen at the ports.
    always_comb begin
        s_sg  = byte_i ? src_i[LANE_W-1] : src_i[DATA_W-1];
        d_sg  = byte_i ? dst_i[LANE_W-1] : dst_i[DATA_W-1];
        r_sg  = byte_i ? res_i[LANE_W-1] : res_i[DATA_W-1];
        r_nil = byte_i ? (res_i[LANE_W-1:0] == '0) : (res_i == '0);
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> psw_o == 4'h0); // R1
    AST_NEG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> psw_o[2] == $past(r_sg)); // R2
    AST_ZERO_RES: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> psw_o[1] == $past(r_nil)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && arith_i && (s_sg != d_sg)) |=> !psw_o[3]); // R4
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && arith_i && (s_sg == d_sg) && (r_sg != s_sg)) |=> psw_o[3]); // R4
    AST_CARRY_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && arith_i && s_sg && d_sg) |=> psw_o[0]); // R5
    AST_CARRY_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && arith_i && !s_sg && !d_sg) |=> !psw_o[0]); // R5
    AST_CV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !arith_i) |=> ($stable(psw_o[0]) && $stable(psw_o[3]))); // R6
    AST_PSW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(psw_o)); // R7

endmodule

bind psw_flag_gen psw_flag_gen_chk #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src_i),
    .dst_i   (dst_i),
    .res_i   (res_i),
    .byte_i  (byte_i),
    .arith_i (arith_i),
    .upd_i   (upd_i),
    .psw_o   (psw_o)
);

// File: tb/sim_psw_flag_gen.sv
`timescale 1ns/1ps
module sim_psw_flag_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src = '0, dst = '0, res = '0;
    logic        byte_m = 1'b0, arith = 1'b0, upd = 1'b0;
    wire  [3:0]  psw;
    logic [3:0]  model = 4'h0;
    int          n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    psw_flag_gen u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .dst_i(dst), .res_i(res),
        .byte_i(byte_m), .arith_i(arith), .upd_i(upd), .psw_o(psw)
    );

    task automatic check(input string req, input logic [3:0] exp);
        n_run++;
        if (psw !== exp) begin
            n_fail++;
            $display("FAIL %s: psw=%b expected=%b", req, psw, exp);
        end
    endtask

    // Drive one operation on the falling edge, let it settle through an edge,
    // then compare on the next falling edge against the reference model.
    task automatic op(input string req, input logic [15:0] s, input logic [15:0] d,
                      input logic [15:0] r, input logic bm, input logic ar, input logic up);
        logic ss, ds, rs, zz;
        @(negedge clk);
        src = s; dst = d; res = r; byte_m = bm; arith = ar; upd = up;
        ss = bm ? s[7] : s[15];
        ds = bm ? d[7] : d[15];
        rs = bm ? r[7] : r[15];
        zz = bm ? (r[7:0] == 8'h00) : (r == 16'h0000);
        if (up) begin
            model[2] = rs;
            model[1] = zz;
            if (ar) begin
                model[3] = (ss == ds) && (rs != ss);
                model[0] = (ss & ds) | (~rs & (ss | ds));
            end
        end
        @(negedge clk);
        upd = 1'b0;
        check(req, model);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model = 4'h0;
        check("R1 reset clear", 4'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_word_cases();
        op("R2 word negative", 16'h7000, 16'h1000, 16'h8000, 1'b0, 1'b1, 1'b1);
        op("R3 word zero", 16'hFFFF, 16'h0001, 16'h0000, 1'b0, 1'b1, 1'b1);
        op("R3 word nonzero high", 16'h0100, 16'h0000, 16'h0100, 1'b0, 1'b1, 1'b1);
        op("R4 word overflow", 16'h8000, 16'h8000, 16'h0000, 1'b0, 1'b1, 1'b1);
    endtask

    // Every sign-bit combination at both sizes; byte mode carries inverted upper bytes.
    task automatic t_sweep();
        for (int k = 0; k < 8; k++) begin
            logic s, d, r;
            {s, d, r} = 3'(k);
            op("R4 R5 word sweep", {s, 15'h0123}, {d, 15'h0456}, {r, 15'h0789}, 1'b0, 1'b1, 1'b1);
            op("R8 byte sweep", {~s, 7'h55, s, 7'h12}, {~d, 7'h2A, d, 7'h34},
               {~r, 7'h11, r, 7'h56}, 1'b1, 1'b1, 1'b1);
        end
    endtask

    task automatic t_byte_zero();
        op("R8 byte zero ignores upper", 16'hAB80, 16'hCD80, 16'hFF00, 1'b1, 1'b1, 1'b1);
        op("R2 byte negative bit7", 16'h8001, 16'h0001, 16'h7F80, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_no_arith();
        op("R6 set C V", 16'h8000, 16'h8000, 16'h0000, 1'b0, 1'b1, 1'b1);
        op("R6 keep C V", 16'h0000, 16'h0000, 16'h8001, 1'b0, 1'b0, 1'b1);
        op("R6 keep C V zero", 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_no_strobe();
        op("R7 prime", 16'hFFFF, 16'hFFFF, 16'hFFFE, 1'b0, 1'b1, 1'b1);
        op("R7 hold word", 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0);
        op("R7 hold byte", 16'h0080, 16'h0000, 16'h0001, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_word_cases();
        t_sweep();
        t_byte_zero();
        t_no_arith();
        t_no_strobe();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule